// File: doc/BRIEF.md
# Serial Transmitter with Line-Break Control

This block sends 8-bit characters on an asynchronous serial line. It has one holding register in front of a shift register. The host writes a byte into the holding register with a one-cycle write strobe. The shift register takes the byte at the next bit boundary and sends a low start bit, eight data bits with the least significant bit first, and a high stop bit. An external rate enable (`tick_i`) sets the bit timing. Normally sixteen ticks make one bit. When the one-tick-per-bit mode input is set (the clock-select value 1111 on the host side), every tick is one bit.

The host steers the transmitter with single-cycle command strobes: enable, disable, start break, stop break and reset. Disable clears the status outputs at once, but any character in the shift or holding register is still sent to the end. A break holds the line low, and it only begins once every queued character has left, including characters written after the command. Stopping a break returns the line high and keeps it high for at least one bit before the next start bit. Reset clears everything in the cycle it is given.

All line transitions happen on bit boundaries taken from a free-running tick counter. A state change that waits for the next boundary can therefore take up to one bit time.

Top module: `uart_tx_brk`

## Requirements
- R1: In the cycle after an enable strobe, with both registers empty, `ready_o` and `empty_o` are both 1.
- R2: A write is accepted only when `ready_o` is 1 in the cycle of the strobe. A write while not ready (holding register full, or transmitter disabled) is dropped, and that byte never appears on the line.
- R3: When `mode_1x_i`=0, each character is sent as one low start bit, eight data bits with bit 0 first, and one high stop bit, each bit lasting 16 ticks. Characters written back to back follow each other with no idle gap.
- R4: When `mode_1x_i`=1, each bit lasts exactly one tick, and the frame is the same as in R3.
- R5: `ready_o` is 1 exactly when the transmitter is enabled and the holding register is empty. `empty_o` is 1 only when `ready_o` is 1 and the shift register is idle, so it is 0 while a character or a break is on the line.
- R6: In the cycle after a disable strobe, `ready_o` and `empty_o` are 0, while characters already accepted are still sent completely. If enable and disable arrive in the same cycle, disable wins.
- R7: Start-break is accepted only while enabled. Once accepted, the line goes low only after the shift register and the holding register have been emptied, including characters written after the command, and it then stays low.
- R8: When start-break is given with both registers empty, the line is low within two bit times.
- R9: After stop-break the line is high within two bit times, and it stays high for at least one full bit time before the next start bit.
- R10: When no character or break is being sent, `txd_o` is high.
- R11: In the cycle after a reset strobe, `txd_o` is 1 and `ready_o` and `empty_o` are 0. Both registers are emptied and any break is cancelled. Nothing more is sent until new data is written after a new enable.
- R12: `txd_o` changes only on the cycle after a bit boundary, or after a reset strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Rate enable, one cycle wide |
| mode_1x_i | input | 1 | 1: one tick per bit; 0: sixteen ticks per bit |
| cmd_en_i | input | 1 | Enable transmitter strobe |
| cmd_dis_i | input | 1 | Disable transmitter strobe |
| cmd_brk_on_i | input | 1 | Start-break strobe |
| cmd_brk_off_i | input | 1 | Stop-break strobe |
| cmd_rst_i | input | 1 | Transmitter reset strobe |
| wr_i | input | 1 | Holding register write strobe |
| wdata_i | input | DATA_W | Character to send |
| txd_o | output | 1 | Serial line, high when marking |
| ready_o | output | 1 | Holding register can accept a byte |
| empty_o | output | 1 | Holding and shift registers both empty |

## Verification
On every cycle, the assertions check how the status outputs relate to each other (R5). They also check the status one cycle after a disable or reset strobe (R6, R11), that the line is high whenever the shifter is idle (R10), and that the line changes only on bit boundaries (R12).

Some behaviour can only be shown by the bench's scenarios, because it spans many bit times or needs counting against the queue of accepted bytes:
- frame contents in both rate modes (R3, R4);
- dropped writes (R2);
- draining after a disable (R6);
- a break that waits behind later writes (R7);
- the two-bit-time limits and the marking gap after a break (R8, R9).

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef enum logic [2:0] {
    TX_IDLE  = 3'd0,
    TX_START = 3'd1,
    TX_DATA  = 3'd2,
    TX_STOP  = 3'd3,
    TX_BRK   = 3'd4,
    TX_GAP   = 3'd5
  } tx_state_e;
endpackage

// File: rtl/tx_bit_timer.sv
module tx_bit_timer #(
  parameter int unsigned OVS = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic tick_i,
  input  logic mode_1x_i,
  output logic bit_stb_o
);
  localparam int unsigned CW = (OVS > 1) ? $clog2(OVS) : 1;
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_i) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
  end

  // one strobe per bit: every tick in 1x mode, else on the last of OVS ticks
  assign bit_stb_o = tick_i & (mode_1x_i | (cnt_q == LAST));
endmodule

// File: rtl/tx_holding.sv
module tx_holding #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              pop_i,
  output logic              full_o,
  output logic [DATA_W-1:0] data_o
);
  logic              full_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (clr_i) begin
      full_q <= 1'b0;
    end else if (load_i) begin
      full_q <= 1'b1;
      data_q <= data_i;
    end else if (pop_i) begin
      full_q <= 1'b0;
    end
  end

  assign full_o = full_q;
  assign data_o = data_q;
endmodule

// File: rtl/tx_shifter.sv
module tx_shifter
  import uart_tx_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              bit_stb_i,
  input  logic              hold_full_i,
  input  logic [DATA_W-1:0] hold_data_i,
  input  logic              brk_req_i,
  output logic              pop_o,
  output logic              busy_o,
  output logic              txd_o,
  output tx_state_e         state_o
);
  localparam int unsigned BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [BW-1:0] LAST_BIT = BW'(DATA_W - 1);

  tx_state_e         state_q, state_d;
  logic [DATA_W-1:0] shreg_q, shreg_d;
  logic [BW-1:0]     bcnt_q, bcnt_d;
  logic              txd_q, txd_d;

  always_comb begin
    state_d = state_q;
    shreg_d = shreg_q;
    bcnt_d  = bcnt_q;
    pop_o   = 1'b0;
    if (bit_stb_i) begin
      unique case (state_q)
        TX_IDLE: begin
          // queued data always goes before a pending break
          if (hold_full_i) begin
            state_d = TX_START;
            shreg_d = hold_data_i;
            pop_o   = 1'b1;
          end else if (brk_req_i) begin
            state_d = TX_BRK;
          end
        end
        TX_START: begin
          state_d = TX_DATA;
          bcnt_d  = '0;
        end
        TX_DATA: begin
          shreg_d = shreg_q >> 1;
          bcnt_d  = bcnt_q + BW'(1);
          if (bcnt_q == LAST_BIT) state_d = TX_STOP;
        end
        TX_STOP: begin
          if (hold_full_i) begin
            state_d = TX_START;
            shreg_d = hold_data_i;
            pop_o   = 1'b1;
          end else if (brk_req_i) begin
            state_d = TX_BRK;
          end else begin
            state_d = TX_IDLE;
          end
        end
        TX_BRK: begin
          if (!brk_req_i) state_d = TX_GAP;
        end
        TX_GAP: begin
          // one full marking bit has elapsed
          if (hold_full_i) begin
            state_d = TX_START;
            shreg_d = hold_data_i;
            pop_o   = 1'b1;
          end else begin
            state_d = TX_IDLE;
          end
        end
        default: state_d = TX_IDLE;
      endcase
    end

    unique case (state_d)
      TX_START: txd_d = 1'b0;
      TX_DATA:  txd_d = shreg_d[0];
      TX_BRK:   txd_d = 1'b0;
      default:  txd_d = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TX_IDLE;
      shreg_q <= '0;
      bcnt_q  <= '0;
      txd_q   <= 1'b1;
    end else if (clr_i) begin
      state_q <= TX_IDLE;
      bcnt_q  <= '0;
      txd_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      shreg_q <= shreg_d;
      bcnt_q  <= bcnt_d;
      txd_q   <= txd_d;
    end
  end

  assign busy_o  = (state_q != TX_IDLE);
  assign txd_o   = txd_q;
  assign state_o = state_q;
endmodule

// File: rtl/uart_tx_brk.sv
module uart_tx_brk
  import uart_tx_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OVS    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              mode_1x_i,
  input  logic              cmd_en_i,
  input  logic              cmd_dis_i,
  input  logic              cmd_brk_on_i,
  input  logic              cmd_brk_off_i,
  input  logic              cmd_rst_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              txd_o,
  output logic              ready_o,
  output logic              empty_o
);
  logic              en_q, brk_q;
  logic              bit_stb;
  logic              hold_full, pop, busy, wr_ok;
  logic [DATA_W-1:0] hold_data;
  tx_state_e         tx_state;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      brk_q <= 1'b0;
    end else if (cmd_rst_i) begin
      en_q  <= 1'b0;
      brk_q <= 1'b0;
    end else begin
      if (cmd_dis_i)     en_q <= 1'b0;
      else if (cmd_en_i) en_q <= 1'b1;
      if (cmd_brk_off_i)             brk_q <= 1'b0;
      else if (cmd_brk_on_i && en_q) brk_q <= 1'b1;
    end
  end

  assign ready_o = en_q & ~hold_full;
  assign empty_o = ready_o & ~busy;
  assign wr_ok   = wr_i & ready_o;

  tx_bit_timer #(.OVS(OVS)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (cmd_rst_i),
    .tick_i    (tick_i),
    .mode_1x_i (mode_1x_i),
    .bit_stb_o (bit_stb)
  );

  tx_holding #(.DATA_W(DATA_W)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cmd_rst_i),
    .load_i (wr_ok),
    .data_i (wdata_i),
    .pop_i  (pop),
    .full_o (hold_full),
    .data_o (hold_data)
  );

  tx_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (cmd_rst_i),
    .bit_stb_i   (bit_stb),
    .hold_full_i (hold_full),
    .hold_data_i (hold_data),
    .brk_req_i   (brk_q),
    .pop_o       (pop),
    .busy_o      (busy),
    .txd_o       (txd_o),
    .state_o     (tx_state)
  );
endmodule

// File: rtl/uart_tx_brk_chk.sv
module uart_tx_brk_chk
  import uart_tx_pkg::*;
(
  input logic      clk_i,
  input logic      rst_ni,
  input logic      cmd_rst_i,
  input logic      cmd_dis_i,
  input logic      txd_i,
  input logic      ready_i,
  input logic      empty_i,
  input logic      bit_stb_i,
  input tx_state_e state_i
);
  assert_empty_needs_ready_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_i |-> ready_i);

  assert_disable_clears_status_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_dis_i |=> (!ready_i && !empty_i));

  assert_reset_cmd_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_rst_i |=> (txd_i && !ready_i && !empty_i));

  assert_idle_marking_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == TX_IDLE) |-> txd_i);

  assert_bit_boundary_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (txd_i != $past(txd_i)) |-> ($past(bit_stb_i) || $past(cmd_rst_i)));
endmodule

bind uart_tx_brk uart_tx_brk_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cmd_rst_i (cmd_rst_i),
  .cmd_dis_i (cmd_dis_i),
  .txd_i     (txd_o),
  .ready_i   (ready_o),
  .empty_i   (empty_o),
  .bit_stb_i (bit_stb),
  .state_i   (tx_state)
);

// File: tb/sim_uart_tx_brk.sv
`timescale 1ns/1ps
module sim_uart_tx_brk;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       mode1x = 1'b0;
  logic       c_en = 1'b0, c_dis = 1'b0, c_bon = 1'b0, c_boff = 1'b0, c_rst = 1'b0;
  logic       wr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic       txd, ready, empty;

  always #2.5 clk = ~clk;

  uart_tx_brk u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .mode_1x_i(mode1x),
    .cmd_en_i(c_en), .cmd_dis_i(c_dis), .cmd_brk_on_i(c_bon),
    .cmd_brk_off_i(c_boff), .cmd_rst_i(c_rst), .wr_i(wr), .wdata_i(wdata),
    .txd_o(txd), .ready_o(ready), .empty_o(empty)
  );

  int tick_per = 1;
  int bit_clks = 16;
  int tcnt = 0;
  always @(posedge clk) begin
    if (tcnt >= tick_per - 1) begin tcnt <= 0; tick <= 1'b1; end
    else begin tcnt <= tcnt + 1; tick <= 1'b0; end
  end

  int checks = 0, fails = 0;
  int rx_cnt = 0, brk_seen = 0;
  bit rx_ignore = 1'b0;
  logic [7:0] exp_q[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // line decoder: mid-bit sampling relative to the detected start edge
  initial begin
    logic [7:0] d;
    logic       stp;
    int         e;
    forever begin
      @(negedge clk);
      if (rst_n && txd == 1'b0) begin
        repeat (bit_clks / 2) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
          repeat (bit_clks) @(negedge clk);
          d[i] = txd;
        end
        repeat (bit_clks) @(negedge clk);
        stp = txd;
        if (!rx_ignore) begin
          if (!stp) brk_seen++;
          else if (exp_q.size() == 0) chk(1'b0, "R2 unexpected frame", d, -1);
          else begin
            e = exp_q.pop_front();
            rx_cnt++;
            chk(d == e[7:0], mode1x ? "R4 frame data" : "R3 frame data", d, e);
          end
        end
        while (txd == 1'b0) @(negedge clk);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "R3 watchdog expired", 0, 1);
    finish_run();
  end

  task automatic pulse(input bit en, input bit dis, input bit bon, input bit boff, input bit rs);
    @(negedge clk);
    c_en = en; c_dis = dis; c_bon = bon; c_boff = boff; c_rst = rs;
    @(negedge clk);
    c_en = 0; c_dis = 0; c_bon = 0; c_boff = 0; c_rst = 0;
  endtask

  task automatic wr_byte(input logic [7:0] b);
    bit acc;
    @(negedge clk);
    acc = ready;
    wr = 1'b1; wdata = b;
    @(negedge clk);
    wr = 1'b0;
    if (acc) exp_q.push_back(b);
  endtask

  task automatic wait_ready();
    while (!ready) @(negedge clk);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2 * bit_clks) @(negedge clk);
  endtask

  task automatic brk_on_empty(input string req);
    int n, b0;
    bit hi;
    b0 = brk_seen;
    pulse(0, 0, 1, 0, 0);
    n = 0;
    while (txd !== 1'b0) begin @(negedge clk); n++; end
    chk(n <= 2 * bit_clks, req, n, 2 * bit_clks);
    chk(empty == 1'b0, "R5 empty low during break", empty, 0);
    while (brk_seen == b0) @(negedge clk);
    pulse(0, 0, 0, 1, 0);
    while (txd !== 1'b1) @(negedge clk);
    hi = 1'b1;
    repeat (3 * bit_clks) begin @(negedge clk); if (txd !== 1'b1) hi = 1'b0; end
    chk(hi, "R10 marking after break", hi, 1);
  endtask

  initial begin
    int r0, b0, n, m;
    bit lo, hi;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(txd == 1'b1, "R10 idle line after reset", txd, 1);
    chk(ready == 1'b0, "R11 ready after reset", ready, 0);
    chk(empty == 1'b0, "R11 empty after reset", empty, 0);

    pulse(1, 0, 0, 0, 0);
    chk(ready == 1'b1, "R1 ready after enable", ready, 1);
    chk(empty == 1'b1, "R1 empty after enable", empty, 1);

    // 16x mode: pattern sweep, back to back
    for (int i = 0; i < 26; i++) begin
      logic [7:0] v;
      v = (i == 0) ? 8'h00 : (i == 1) ? 8'hFF : 8'((i * 37 + 5) & 255);
      wait_ready();
      wr_byte(v);
    end
    drain();

    // status with both registers occupied
    wr_byte(8'h3C);
    wait_ready();
    wr_byte(8'hC3);
    chk(ready == 1'b0, "R5 ready with holding full", ready, 0);
    chk(empty == 1'b0, "R5 empty while shifting", empty, 0);
    drain();
    chk(ready && empty, "R5 status after drain", {ready, empty}, 3);

    // R2: write while full is dropped
    r0 = rx_cnt;
    wr_byte(8'h11);
    wait_ready();
    wr_byte(8'h22);
    wr_byte(8'h33);
    drain();
    chk(rx_cnt == r0 + 2, "R2 frames after dropped write", rx_cnt - r0, 2);

    // R6: disable drains
    r0 = rx_cnt;
    wr_byte(8'h44);
    wait_ready();
    wr_byte(8'h55);
    pulse(0, 1, 0, 0, 0);
    chk(!ready && !empty, "R6 status after disable", {ready, empty}, 0);
    wr_byte(8'h66);
    drain();
    chk(rx_cnt == r0 + 2, "R6 frames drained after disable", rx_cnt - r0, 2);
    chk(txd == 1'b1, "R10 idle after drain", txd, 1);
    pulse(1, 1, 0, 0, 0);
    chk(ready == 1'b0, "R6 disable wins over enable", ready, 0);
    pulse(0, 0, 1, 0, 0);
    repeat (3 * bit_clks) @(negedge clk);
    chk(txd == 1'b1, "R7 break ignored while disabled", txd, 1);
    pulse(1, 0, 0, 0, 0);
    chk(ready && empty, "R1 re-enable", {ready, empty}, 3);

    // R7: break waits for queued and later data
    r0 = rx_cnt;
    b0 = brk_seen;
    wr_byte(8'h81);
    wait_ready();
    wr_byte(8'h7E);
    pulse(0, 0, 1, 0, 0);
    wait_ready();
    wr_byte(8'hE7);
    while (brk_seen == b0) @(negedge clk);
    chk(rx_cnt == r0 + 3, "R7 data sent before break", rx_cnt - r0, 3);
    lo = 1'b1;
    repeat (3 * bit_clks) begin @(negedge clk); if (txd !== 1'b0) lo = 1'b0; end
    chk(lo, "R7 line held low in break", lo, 1);
    wr_byte(8'h96);
    chk(empty == 1'b0, "R5 empty low during break", empty, 0);
    pulse(0, 0, 0, 1, 0);
    n = 0;
    while (txd !== 1'b1) begin @(negedge clk); n++; end
    chk(n <= 2 * bit_clks, "R9 high after stop-break", n, 2 * bit_clks);
    m = 0;
    while (txd !== 1'b0) begin @(negedge clk); m++; end
    chk(m >= bit_clks, "R9 marking gap before next start", m, bit_clks);
    drain();

    brk_on_empty("R8 break delay 16x");

    // R11: reset mid-character
    wr_byte(8'hA0);
    repeat (3 * bit_clks) @(negedge clk);
    rx_ignore = 1'b1;
    pulse(0, 0, 0, 0, 1);
    chk(txd == 1'b1, "R11 line high after reset", txd, 1);
    chk(!ready && !empty, "R11 status after reset", {ready, empty}, 0);
    exp_q.delete();
    repeat (12 * bit_clks) @(negedge clk);
    chk(txd == 1'b1, "R11 nothing sent after reset", txd, 1);
    rx_ignore = 1'b0;
    pulse(1, 0, 0, 0, 0);
    chk(ready && empty, "R11 registers empty", {ready, empty}, 3);

    // R11: reset cancels break
    pulse(0, 0, 1, 0, 0);
    repeat (3 * bit_clks) @(negedge clk);
    chk(txd == 1'b0, "R8 break active", txd, 0);
    rx_ignore = 1'b1;
    pulse(0, 0, 0, 0, 1);
    chk(txd == 1'b1, "R11 break cancelled", txd, 1);
    hi = 1'b1;
    repeat (12 * bit_clks) begin @(negedge clk); if (txd !== 1'b1) hi = 1'b0; end
    chk(hi, "R11 break stays cancelled", hi, 1);
    rx_ignore = 1'b0;

    // 1x mode: full byte sweep
    mode1x = 1'b1;
    tick_per = 4;
    bit_clks = 4;
    pulse(0, 0, 0, 0, 1);
    pulse(1, 0, 0, 0, 0);
    r0 = rx_cnt;
    for (int v = 0; v < 256; v++) begin
      wait_ready();
      wr_byte(8'(v));
    end
    drain();
    chk(rx_cnt == r0 + 256, "R4 all bytes in 1x mode", rx_cnt - r0, 256);
    brk_on_empty("R8 break delay 1x (R4)");

    repeat (10) @(negedge clk);
    finish_run();
  end
endmodule